// File: doc/BRIEF.md
# Modulator Output Conditioning Path

This block conditions transmit samples on their way to two modulator outputs and one audio output. Each modulator channel is scaled by a fine attenuation factor, has a signed correction value taken away, and is then clipped symmetrically about zero at a programmable deviation. The audio channel shares the first channel's attenuation but bypasses the correction and clipping steps. It feeds a later coarse gain stage and converter, which are not part of this block.

Samples arrive as signed 16-bit words with a valid strobe. The attenuation codes, correction values and clip level arrive as plain input ports. The block copies them into holding registers only while no sample is being processed. Results appear two clock cycles after the sample is accepted, together with an output valid strobe.

Top module: `txcond_path`

## Requirements
- R1: While reset is asserted, and until the first sample completes, `out_valid` is 0 and all three sample outputs are 0.
- R2: An attenuation code of 0 passes samples unchanged, given zero correction and a clip code of 0x3FFF. The one exception is a modulator sample of -32768, which the clip stage turns into -32767. The audio output keeps -32768.
- R3: A code G scales a sample x to floor((x*(32768-G) + 16384) / 32768), which is rounding to nearest with halves rounded upward.
- R4: Codes above 10900 act exactly like 10900, which limits the attenuation to about -3.5 dB.
- R5: `fgain1` scales both `mod1_out` and `aud_out`, and `fgain2` scales `mod2_out`. The audio output is not affected by the correction or clip settings.
- R6: Each modulator channel subtracts its two's-complement correction from the scaled sample. The difference saturates to the range -32768..32767.
- R7: The 14-bit clip code L sets the deviation D = 2*L + L[13]. A modulator result above D becomes D, and one below -D becomes -D. With L = 0x3FFF, D is 32767.
- R8: Every accepted sample produces exactly one result. `out_valid` rises for that result exactly 2 cycles after the accepting edge, and results come out in input order.
- R9: The settings ports are copied into the holding registers only on an edge where `in_valid` is low and neither pipeline stage holds a sample. Any change made during a back-to-back stream is ignored until the stream has drained.
- R10: While `out_valid` is low, all three sample outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_mod1 | input | 16 | Signed sample for modulator channel 1 |
| in_mod2 | input | 16 | Signed sample for modulator channel 2 |
| in_aud | input | 16 | Signed sample for the audio channel |
| fgain1 | input | 16 | Attenuation code for channel 1 and audio |
| fgain2 | input | 16 | Attenuation code for channel 2 |
| offs1 | input | 16 | Two's-complement correction for channel 1 |
| offs2 | input | 16 | Two's-complement correction for channel 2 |
| clip_lvl | input | 14 | Unsigned clip code shared by both modulator channels |
| out_valid | output | 1 | Result strobe |
| mod1_out | output | 16 | Conditioned channel 1 sample |
| mod2_out | output | 16 | Conditioned channel 2 sample |
| aud_out | output | 16 | Attenuated audio sample |

## Verification
Some properties are checked by assertions on every cycle:
- the two-cycle valid latency;
- both modulator outputs staying inside plus or minus the held deviation;
- the audio output never exceeding the magnitude of its input;
- the holding registers staying frozen while a sample is in flight;
- the outputs holding still between results.

Other behaviour needs exact expected values from the bench scenarios:
- the rounding rule;
- the code saturation at 10900;
- the saturating subtraction at both ends;
- the deviation mapping of the clip code;
- the point at which a changed setting takes effect after a stream.

// File: rtl/txc_pkg.sv
package txc_pkg;
  // Default geometry of the conditioning path
  localparam int unsigned TXC_DW   = 16;    // sample and register width
  localparam int unsigned TXC_LW   = 14;    // clip code width
  localparam int unsigned TXC_GMAX = 10900; // largest useful attenuation code

  // Channel indices inside the datapath arrays
  localparam int unsigned CH_MOD1 = 0;
  localparam int unsigned CH_MOD2 = 1;
  localparam int unsigned CH_AUD  = 2;
  localparam int unsigned N_GAIN  = 3;      // scaled channels
  localparam int unsigned N_MOD   = 2;      // channels with correction and clip
endpackage

// File: rtl/txc_fine_gain.sv
// Combinational attenuation: y = round(x * (2^(DW-1) - g) / 2^(DW-1))
module txc_fine_gain
  import txc_pkg::*;
#(
  parameter int unsigned DW   = TXC_DW,
  parameter int unsigned GMAX = TXC_GMAX
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] g,
  output logic [DW-1:0] y
);
  localparam int unsigned PW   = 2*DW + 2;
  localparam int unsigned ONE  = 1 << (DW-1);
  localparam int unsigned HALF = ONE >> 1;

  logic [DW-1:0]        g_lim;
  logic [DW:0]          fac;
  logic signed [PW-1:0] xe;
  logic signed [PW-1:0] fe;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] shr;

  always_comb begin
    g_lim = (g > DW'(GMAX)) ? DW'(GMAX) : g;
    fac   = (DW+1)'(ONE) - {1'b0, g_lim};
    xe    = PW'($signed(x));
    fe    = $signed({{(PW-DW-1){1'b0}}, fac});
    prod  = xe * fe;
    rnd   = prod + $signed(PW'(HALF));
    shr   = rnd >>> (DW-1);
    y     = shr[DW-1:0];
  end
endmodule

// File: rtl/txc_ofs_clip.sv
// Combinational saturating subtract followed by a symmetric clip about zero
module txc_ofs_clip
  import txc_pkg::*;
#(
  parameter int unsigned DW = TXC_DW,
  parameter int unsigned LW = TXC_LW
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] ofs,
  input  logic [LW-1:0] lim,
  output logic [DW-1:0] y
);
  localparam int unsigned SH   = DW - 1 - LW;
  localparam logic [DW-1:0] FILL = DW'((1 << SH) - 1);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0]   diff;
  logic [DW-1:0]        sat;
  logic [DW-1:0]        dev;
  logic signed [DW-1:0] s_sat;
  logic signed [DW-1:0] s_dev;
  logic signed [DW-1:0] s_ndev;

  always_comb begin
    diff = $signed({x[DW-1], x}) - $signed({ofs[DW-1], ofs});
    if (diff[DW] != diff[DW-1]) sat = diff[DW] ? SMIN : SMAX;
    else                        sat = diff[DW-1:0];
    dev    = (DW'(lim) << SH) | (lim[LW-1] ? FILL : '0);
    s_sat  = $signed(sat);
    s_dev  = $signed(dev);
    s_ndev = -s_dev;
    if (s_sat > s_dev)       y = dev;
    else if (s_sat < s_ndev) y = s_ndev;
    else                     y = sat;
  end
endmodule

// File: rtl/txc_cfg_hold.sv
// Holding registers for the settings, loaded only when the path is empty
module txc_cfg_hold
  import txc_pkg::*;
#(
  parameter int unsigned DW = TXC_DW,
  parameter int unsigned LW = TXC_LW
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] g1_in,
  input  logic [DW-1:0] g2_in,
  input  logic [DW-1:0] o1_in,
  input  logic [DW-1:0] o2_in,
  input  logic [LW-1:0] lim_in,
  output logic [DW-1:0] g1_q,
  output logic [DW-1:0] g2_q,
  output logic [DW-1:0] o1_q,
  output logic [DW-1:0] o2_q,
  output logic [LW-1:0] lim_q
);
  logic [DW-1:0] g1_d, g2_d, o1_d, o2_d;
  logic [LW-1:0] lim_d;

  always_comb begin
    g1_d  = g1_q;
    g2_d  = g2_q;
    o1_d  = o1_q;
    o2_d  = o2_q;
    lim_d = lim_q;
    if (cap_en) begin
      g1_d  = g1_in;
      g2_d  = g2_in;
      o1_d  = o1_in;
      o2_d  = o2_in;
      lim_d = lim_in;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      g1_q  <= '0;
      g2_q  <= '0;
      o1_q  <= '0;
      o2_q  <= '0;
      lim_q <= '0;
    end else begin
      g1_q  <= g1_d;
      g2_q  <= g2_d;
      o1_q  <= o1_d;
      o2_q  <= o2_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/txcond_path.sv
module txcond_path
  import txc_pkg::*;
#(
  parameter int unsigned DW   = TXC_DW,
  parameter int unsigned LW   = TXC_LW,
  parameter int unsigned GMAX = TXC_GMAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_mod1,
  input  logic [DW-1:0] in_mod2,
  input  logic [DW-1:0] in_aud,
  input  logic [DW-1:0] fgain1,
  input  logic [DW-1:0] fgain2,
  input  logic [DW-1:0] offs1,
  input  logic [DW-1:0] offs2,
  input  logic [LW-1:0] clip_lvl,
  output logic          out_valid,
  output logic [DW-1:0] mod1_out,
  output logic [DW-1:0] mod2_out,
  output logic [DW-1:0] aud_out
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // Pipeline occupancy and settings capture
  logic v1_q, v1_d, v2_q, v2_d;
  logic busy;

  assign busy = in_valid | v1_q | v2_q;

  logic [DW-1:0] sh_g1, sh_g2, sh_o1, sh_o2;
  logic [LW-1:0] sh_lim;

  txc_cfg_hold #(.DW(DW), .LW(LW)) u_cfg (
    .clk    (clk),
    .srst_n (srst_n),
    .cap_en (~busy),
    .g1_in  (fgain1),
    .g2_in  (fgain2),
    .o1_in  (offs1),
    .o2_in  (offs2),
    .lim_in (clip_lvl),
    .g1_q   (sh_g1),
    .g2_q   (sh_g2),
    .o1_q   (sh_o1),
    .o2_q   (sh_o2),
    .lim_q  (sh_lim)
  );

  // Stage 1: attenuation on all three channels
  logic [DW-1:0] raw   [N_GAIN];
  logic [DW-1:0] gsel  [N_GAIN];
  logic [DW-1:0] gained[N_GAIN];
  logic [DW-1:0] s1_d  [N_GAIN];
  logic [DW-1:0] s1_q  [N_GAIN];

  assign raw[CH_MOD1]  = in_mod1;
  assign raw[CH_MOD2]  = in_mod2;
  assign raw[CH_AUD]   = in_aud;
  assign gsel[CH_MOD1] = sh_g1;
  assign gsel[CH_MOD2] = sh_g2;
  assign gsel[CH_AUD]  = sh_g1;   // audio follows the channel 1 code

  generate
    for (genvar c = 0; c < N_GAIN; c++) begin : g_gain
      txc_fine_gain #(.DW(DW), .GMAX(GMAX)) u_gain (
        .x (raw[c]),
        .g (gsel[c]),
        .y (gained[c])
      );
    end
  endgenerate

  // Stage 2: correction and clip on the modulator channels only
  logic [DW-1:0] osel  [N_MOD];
  logic [DW-1:0] fixed [N_MOD];
  logic [DW-1:0] res_d [N_GAIN];
  logic [DW-1:0] res_q [N_GAIN];

  assign osel[CH_MOD1] = sh_o1;
  assign osel[CH_MOD2] = sh_o2;

  generate
    for (genvar c = 0; c < N_MOD; c++) begin : g_mod
      txc_ofs_clip #(.DW(DW), .LW(LW)) u_clip (
        .x   (s1_q[c]),
        .ofs (osel[c]),
        .lim (sh_lim),
        .y   (fixed[c])
      );
    end
  endgenerate

  // Next-state logic with explicit enables
  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
    for (int c = 0; c < N_GAIN; c++) begin
      s1_d[c]  = in_valid ? gained[c] : s1_q[c];
      res_d[c] = res_q[c];
    end
    if (v1_q) begin
      for (int c = 0; c < N_MOD; c++) res_d[c] = fixed[c];
      res_d[CH_AUD] = s1_q[CH_AUD];
    end
  end

  // State registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      for (int c = 0; c < N_GAIN; c++) begin
        s1_q[c]  <= '0;
        res_q[c] <= '0;
      end
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      for (int c = 0; c < N_GAIN; c++) begin
        s1_q[c]  <= s1_d[c];
        res_q[c] <= res_d[c];
      end
    end
  end

  assign out_valid = v2_q;
  assign mod1_out  = res_q[CH_MOD1];
  assign mod2_out  = res_q[CH_MOD2];
  assign aud_out   = res_q[CH_AUD];
endmodule

// File: rtl/txcond_path_chk.sv
module txcond_path_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 14
) (
  input logic                 clk,
  input logic                 srst_n,
  input logic                 in_valid,
  input logic [DW-1:0]        in_aud,
  input logic                 busy,
  input logic [LW-1:0]        sh_lim,
  input logic [4*DW+LW-1:0]   sh_all,
  input logic                 out_valid,
  input logic [DW-1:0]        mod1_out,
  input logic [DW-1:0]        mod2_out,
  input logic [DW-1:0]        aud_out
);
  localparam int unsigned SH = DW - 1 - LW;

  logic [1:0]    cnt;
  logic [DW-1:0] aud_d1, aud_d2;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt    <= '0;
      aud_d1 <= '0;
      aud_d2 <= '0;
    end else begin
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
      aud_d1 <= in_aud;
      aud_d2 <= aud_d1;
    end
  end

  function automatic logic [DW:0] mag(input logic [DW-1:0] v);
    logic signed [DW:0] e;
    e = $signed({v[DW-1], v});
    return e[DW] ? DW'(0) - e : e;
  endfunction

  logic signed [DW:0] dev_s;
  logic signed [DW:0] m1_s, m2_s;
  logic [DW:0]        mag_out, mag_in;

  always_comb begin
    dev_s   = $signed({1'b0, (DW'(sh_lim) << SH) | (sh_lim[LW-1] ? DW'((1 << SH) - 1) : DW'(0))});
    m1_s    = $signed({mod1_out[DW-1], mod1_out});
    m2_s    = $signed({mod2_out[DW-1], mod2_out});
    mag_out = mag(aud_out);
    mag_in  = mag(aud_d2);
  end

  // R1: no result while the internal reset is held
  always @(negedge clk) begin
    if (!srst_n) begin
      a_r1_quiet_in_reset: assert (!out_valid && mod1_out == '0 && mod2_out == '0 && aud_out == '0);
    end
  end

  // R8
  a_r8_two_cycle_valid: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R7
  a_r7_mod1_in_window: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> (m1_s <= dev_s && m1_s >= -dev_s));

  a_r7_mod2_in_window: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid |-> (m2_s <= dev_s && m2_s >= -dev_s));

  // R5: audio is only ever attenuated
  a_r5_aud_no_boost: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt >= 2'd2 && out_valid) |-> (mag_out <= mag_in));

  // R9
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!srst_n)
    busy |=> $stable(sh_all));

  // R10
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt >= 2'd1 && !out_valid) |-> ($stable(mod1_out) && $stable(mod2_out) && $stable(aud_out)));
endmodule

bind txcond_path txcond_path_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_aud    (in_aud),
  .busy      (busy),
  .sh_lim    (sh_lim),
  .sh_all    ({sh_g1, sh_g2, sh_o1, sh_o2, sh_lim}),
  .out_valid (out_valid),
  .mod1_out  (mod1_out),
  .mod2_out  (mod2_out),
  .aud_out   (aud_out)
);

// File: tb/txcond_path_tb.sv
module txcond_path_tb;
  localparam int GMAX = 10900;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_mod1, in_mod2, in_aud;
  logic [15:0] fgain1, fgain2, offs1, offs2;
  logic [13:0] clip_lvl;
  logic        out_valid;
  logic [15:0] mod1_out, mod2_out, aud_out;

  always #10 clk = ~clk;   // 50 MHz

  txcond_path u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_mod1(in_mod1), .in_mod2(in_mod2), .in_aud(in_aud),
    .fgain1(fgain1), .fgain2(fgain2), .offs1(offs1), .offs2(offs2),
    .clip_lvl(clip_lvl), .out_valid(out_valid),
    .mod1_out(mod1_out), .mod2_out(mod2_out), .aud_out(aud_out)
  );

  typedef struct {
    int     m1;
    int     m2;
    int     au;
    longint due;
    string  tag;
  } item_t;

  item_t  sb[$];
  int     n_chk = 0;
  int     n_bad = 0;
  longint cyc = 0;
  bit     mon_on = 1'b0;
  bit     h1 = 1'b0, h2 = 1'b0;
  int     k_g1, k_g2, k_o1, k_o2, k_lim;
  string  tag_cur = "R2";
  int     last_m1 = 0, last_m2 = 0, last_au = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model built from the requirements
  function automatic int ref_gain(int x, int g);
    longint p;
    if (g > GMAX) g = GMAX;                       // R4
    p = longint'(x) * longint'(32768 - g) + 64'sd16384;
    return int'(p >>> 15);                        // R3
  endfunction

  function automatic int ref_mod(int r, int o, int l);
    int d, dv;
    d = r - o;                                    // R6
    if (d > 32767)  d = 32767;
    if (d < -32768) d = -32768;
    dv = 2*l + (l >> 13);                         // R7
    if (d > dv)  d = dv;
    if (d < -dv) d = -dv;
    return d;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle of driving; model mirrors the capture rule of R9
  task automatic step();
    item_t it;
    if (!in_valid && !h1 && !h2) begin
      k_g1  = int'(fgain1);
      k_g2  = int'(fgain2);
      k_o1  = int'($signed(offs1));
      k_o2  = int'($signed(offs2));
      k_lim = int'(clip_lvl);
    end
    if (in_valid) begin
      it.m1  = ref_mod(ref_gain(int'($signed(in_mod1)), k_g1), k_o1, k_lim);
      it.m2  = ref_mod(ref_gain(int'($signed(in_mod2)), k_g2), k_o2, k_lim);
      it.au  = ref_gain(int'($signed(in_aud)), k_g1);   // R5
      it.due = cyc + 2;
      it.tag = tag_cur;
      sb.push_back(it);
    end
    h2 = h1;
    h1 = in_valid;
    @(negedge clk);
  endtask

  task automatic send(int a, int b, int c, string tag);
    in_valid = 1'b1;
    in_mod1  = a[15:0];
    in_mod2  = b[15:0];
    in_aud   = c[15:0];
    tag_cur  = tag;
    step();
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(int g1, int g2, int o1, int o2, int l);
    fgain1   = g1[15:0];
    fgain2   = g2[15:0];
    offs1    = o1[15:0];
    offs2    = o2[15:0];
    clip_lvl = l[13:0];
  endtask

  // Monitor: pop and compare; R8 timing, R10 hold
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check("R8", 1, 0, "unexpected out_valid");
        end else begin
          item_t it;
          it = sb.pop_front();
          check("R8", int'(cyc), int'(it.due), "result cycle");
          check(it.tag, int'($signed(mod1_out)), it.m1, "mod1_out");
          check(it.tag, int'($signed(mod2_out)), it.m2, "mod2_out");
          check(it.tag, int'($signed(aud_out)),  it.au, "aud_out");
        end
        last_m1 = int'($signed(mod1_out));
        last_m2 = int'($signed(mod2_out));
        last_au = int'($signed(aud_out));
      end else begin
        check("R10", int'($signed(mod1_out)), last_m1, "mod1_out hold");
        check("R10", int'($signed(mod2_out)), last_m2, "mod2_out hold");
        check("R10", int'($signed(aud_out)),  last_au, "aud_out hold");
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_mod1 = '0; in_mod2 = '0; in_aud = '0;
    cfg(0, 0, 0, 0, 16'h3FFF);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0, "out_valid in reset");
    check("R1", int'(mod1_out), 0, "mod1_out in reset");
    check("R1", int'(mod2_out), 0, "mod2_out in reset");
    check("R1", int'(aud_out), 0, "aud_out in reset");
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(4);

    // R2: unity code
    send(1000, -1000, 500, "R2");
    send(32767, -32768, -32768, "R2");
    send(0, 1, -1, "R2");
    idle(3);

    // R3: general attenuation and rounding
    cfg(5000, 1234, 0, 0, 16'h3FFF);
    idle(3);
    send(12345, -12345, 7, "R3");
    send(-7, 32767, -32768, "R3");
    send(3, -3, 20000, "R3");
    send(-1, 1, -2, "R3");
    idle(3);

    // R4: codes beyond the maximum
    cfg(20000, 65535, 0, 0, 16'h3FFF);
    idle(3);
    send(30000, -30000, 30000, "R4");
    send(-32768, 32767, -12345, "R4");
    idle(3);

    // R5: channel 1 code drives audio; audio skips correction and clip
    cfg(3000, 0, 4000, 0, 500);
    idle(3);
    send(20000, 20000, 20000, "R5");
    send(-20000, 300, -20000, "R5");
    idle(3);

    // R6: saturating subtraction
    cfg(0, 0, -32768, 32767, 16'h3FFF);
    idle(3);
    send(32767, -32768, 0, "R6");
    send(100, 100, 0, "R6");
    cfg(0, 0, -50, 50, 16'h3FFF);
    idle(3);
    send(1000, 1000, 0, "R6");
    idle(3);

    // R7: clip deviation mapping
    cfg(0, 0, 0, 0, 1000);
    idle(3);
    send(5000, -5000, 0, "R7");
    send(2000, -2000, 0, "R7");
    send(2001, -2001, 0, "R7");
    cfg(0, 0, 0, 0, 16'h2000);
    idle(3);
    send(20000, -20000, 0, "R7");
    send(16385, -16386, 0, "R7");
    cfg(0, 0, 0, 0, 0);
    idle(3);
    send(5, -5, 9, "R7");
    idle(3);

    // R9: settings changed during a stream take effect only after it drains
    cfg(2000, 4000, 100, -100, 16'h1000);
    idle(3);
    for (int i = 0; i < 10; i++) begin
      if (i == 4) cfg(9000, 0, -3000, 3000, 16'h0100);
      in_valid = 1'b1;
      in_mod1  = 16'(i * 3001 - 12000);
      in_mod2  = 16'(12000 - i * 2777);
      in_aud   = 16'(i * 1111);
      tag_cur  = "R9";
      step();
    end
    idle(3);
    send(12000, -12000, 12000, "R9");
    send(-300, 300, -300, "R9");
    idle(6);

    check("R8", sb.size(), 0, "pending results at end");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule